// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block keeps the privileged control state of a small scalar core: a status word, a cause word, the saved exception PC, the exception vector, the faulting-address register and a retire counter with a compare register. At every instruction boundary (a `step_i` strobe) it decides whether a pending and unmasked interrupt must be taken. Independently, a synchronous trap can be raised with a valid strobe and a trap number. On trap entry the block updates its state and reports a one-cycle redirect together with the vector address that fetch must jump to.

Software reaches the state through one write port with a target selector. Status writes are filtered according to build-time feature parameters. The block also reports the integer register width that applies in the current privilege mode. A trap raised while traps are disabled, or one with an undefined trap number, does not enter the handler; it raises a sticky error output instead.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the cause, exception PC, vector, faulting address, counter, compare, redirect target, redirect and error outputs are 0. The status is 0x0060 (supervisor bit 6 and supervisor-64 bit 5 set, after R2 filtering).
- R2: Status layout: bit0 trap enable, bit1 FP enable, bit2 compressed enable, bit3 reserved, bit4 user-64, bit5 supervisor-64, bit6 supervisor, bit7 previous supervisor, bits15:8 interrupt mask. Every status value is filtered: bit3 is cleared, bits 4 and 5 are cleared if 64-bit support is off, bit1 is cleared if the FPU is absent and bit2 is cleared if compressed instructions are absent. The default build has 64-bit on, FPU off and compressed off, so a write of 0xFFFF reads back 0xFFF1.
- R3: `xlen_o` is 64 when the 64-bit bit of the current mode is 1 and 32 otherwise. The current mode is supervisor when bit6 is 1, which selects bit5; otherwise bit4 is used.
- R4: An interrupt is taken on a cycle with `step_i`=1 when (cause bits15:8 AND status bits15:8) is nonzero and status bit0 is 1. A taken trap shows `redirect_o`=1 for exactly the following cycle.
- R5: Trap entry clears bit0, sets bit6 and copies the old bit6 into bit7. All other status bits stay unchanged.
- R6: Cause layout: bits4:0 exception code, bits7:5 reserved zero, bits15:8 pending. Trap entry replaces only bits4:0 with the trap number. It also loads the exception PC from `pc_i`, the faulting address from `bad_addr_i` and `redirect_pc_o` from the vector held before the entry.
- R7: The counter increments on every `step_i`. When its value before the increment equals compare, pending bit 7 (cause bit15) is set. Bits set on `irq_set_i` are ORed into the pending field every cycle.
- R8: A synchronous trap that is not pre-empted by an interrupt and arrives with status bit0 equal to 0 sets `err_o` (sticky). It causes no trap entry and no state change.
- R9: A synchronous trap number of 16 or more (NUM_TRAPS) sets `err_o` and is otherwise ignored.
- R10: If an interrupt and a synchronous trap occur in the same cycle, the interrupt is taken and its code is 31 (IRQ_CODE). The synchronous trap is dropped without error.
- R11: Write selector codes: 0 status, 1 cause (reserved bits7:5 cleared), 2 vector, 3 compare, 4 exception PC. Other codes change nothing, and a write in the same cycle as a trap entry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One instruction retires at this boundary |
| pc_i | input | ADDR_W | PC of the current instruction |
| trap_valid_i | input | 1 | Synchronous trap request |
| trap_code_i | input | 5 | Synchronous trap number |
| bad_addr_i | input | ADDR_W | Faulting virtual address |
| irq_set_i | input | 8 | Pending-interrupt set pulses |
| wr_en_i | input | 1 | Control write strobe |
| wr_sel_i | input | 3 | Write target selector |
| wr_data_i | input | ADDR_W | Write data |
| status_o | output | 16 | Status word |
| cause_o | output | 16 | Cause word |
| epc_o | output | ADDR_W | Saved exception PC |
| evec_o | output | ADDR_W | Exception vector |
| badaddr_o | output | ADDR_W | Faulting-address register |
| count_o | output | CNT_W | Retire counter |
| compare_o | output | CNT_W | Timer compare value |
| redirect_o | output | 1 | Trap entry happened last cycle |
| redirect_pc_o | output | ADDR_W | Handler address of the latest entry |
| xlen_o | output | 7 | Active integer width (32 or 64) |
| err_o | output | 1 | Sticky fatal/undefined trap flag |

## Verification
The assertions assume that `wr_sel_i`, `trap_code_i` and the strobes are known values whenever reset is released, and that a redirect cycle is not itself reported as an illegal entry. The stimulus drives every input on the falling edge, so values are settled at the sampling edge. Random trap numbers span all 32 codes so that undefined numbers occur. Status writes regularly set the enable bit again so that trap entry keeps happening after the first trap has cleared it.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;
    localparam int ST_W     = 16;
    localparam int CA_W     = 16;
    localparam int NIRQ     = 8;
    localparam int CODE_W   = 5;

    // status field positions
    localparam int ST_TE    = 0;
    localparam int ST_FPEN  = 1;
    localparam int ST_CMPEN = 2;
    localparam int ST_RSV   = 3;
    localparam int ST_U64   = 4;
    localparam int ST_S64   = 5;
    localparam int ST_SUP   = 6;
    localparam int ST_PSUP  = 7;
    localparam int ST_MASK  = 8;

    // cause field positions
    localparam int CA_PEND  = 8;
    localparam logic [CA_W-1:0] CA_RSV_MASK = 16'h00E0;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_CAUSE   = 3'd1,
        SEL_EVEC    = 3'd2,
        SEL_COMPARE = 3'd3,
        SEL_EPC     = 3'd4
    } ctl_sel_e;

    function automatic logic [ST_W-1:0] filter_status(
        input logic [ST_W-1:0] v,
        input bit has_rv64,
        input bit has_fpu,
        input bit has_cmp
    );
        logic [ST_W-1:0] r;
        r = v;
        r[ST_RSV] = 1'b0;
        if (!has_rv64) begin
            r[ST_U64] = 1'b0;
            r[ST_S64] = 1'b0;
        end
        if (!has_fpu) r[ST_FPEN]  = 1'b0;
        if (!has_cmp) r[ST_CMPEN] = 1'b0;
        return r;
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_ctrl_pkg::*;
#(
    parameter int NUM_TRAPS = 16,
    parameter int IRQ_CODE  = 31
) (
    input  logic              step_i,
    input  logic              te_i,
    input  logic [NIRQ-1:0]   pend_i,
    input  logic [NIRQ-1:0]   mask_i,
    input  logic              trap_valid_i,
    input  logic [CODE_W-1:0] trap_code_i,
    output logic              irq_take_o,
    output logic              entry_o,
    output logic              bad_o,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W:0]   LIMIT    = (CODE_W+1)'(NUM_TRAPS);
    localparam logic [CODE_W-1:0] IRQ_CODE_L = CODE_W'(IRQ_CODE);

    logic code_ok;
    logic sync_req;

    always_comb begin
        irq_take_o = step_i && te_i && (|(pend_i & mask_i));
        code_ok    = {1'b0, trap_code_i} < LIMIT;
        sync_req   = trap_valid_i && !irq_take_o;
        entry_o    = irq_take_o || (sync_req && te_i && code_ok);
        bad_o      = sync_req && !(te_i && code_ok);
        code_o     = irq_take_o ? IRQ_CODE_L : trap_code_i;
    end
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
    parameter int CNT_W = 32
) (
    input  logic             step_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] count_next_o,
    output logic             hit_o
);
    always_comb begin
        count_next_o = step_i ? count_i + CNT_W'(1) : count_i;
        hit_o        = step_i && (count_i == compare_i);
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 32,
    parameter int NUM_TRAPS   = 16,
    parameter int IRQ_CODE    = 31,
    parameter int TIMER_IRQ   = 7,
    parameter bit HAS_RV64    = 1'b1,
    parameter bit HAS_FPU     = 1'b0,
    parameter bit HAS_COMPACT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              trap_valid_i,
    input  logic [4:0]        trap_code_i,
    input  logic [ADDR_W-1:0] bad_addr_i,
    input  logic [7:0]        irq_set_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [15:0]       status_o,
    output logic [15:0]       cause_o,
    output logic [ADDR_W-1:0] epc_o,
    output logic [ADDR_W-1:0] evec_o,
    output logic [ADDR_W-1:0] badaddr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  compare_o,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] redirect_pc_o,
    output logic [6:0]        xlen_o,
    output logic              err_o
);
    localparam logic [ST_W-1:0] ST_RST =
        filter_status(ST_W'((1 << ST_SUP) | (1 << ST_S64)), HAS_RV64, HAS_FPU, HAS_COMPACT);
    localparam int TMR_BIT = CA_PEND + TIMER_IRQ;

    typedef struct packed {
        logic [ST_W-1:0]   status;
        logic [CA_W-1:0]   cause;
        logic [ADDR_W-1:0] epc;
        logic [ADDR_W-1:0] evec;
        logic [ADDR_W-1:0] badaddr;
        logic [ADDR_W-1:0] rpc;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  compare;
        logic              redirect;
        logic              err;
    } state_t;

    state_t s_d, s_q;

    logic              irq_take, entry, bad_trap, tmr_hit;
    logic [CODE_W-1:0] entry_code;
    logic [CNT_W-1:0]  count_next;
    ctl_sel_e          sel;

    trap_arbiter #(
        .NUM_TRAPS (NUM_TRAPS),
        .IRQ_CODE  (IRQ_CODE)
    ) u_arb (
        .step_i       (step_i),
        .te_i         (s_q.status[ST_TE]),
        .pend_i       (s_q.cause[CA_PEND +: NIRQ]),
        .mask_i       (s_q.status[ST_MASK +: NIRQ]),
        .trap_valid_i (trap_valid_i),
        .trap_code_i  (trap_code_i),
        .irq_take_o   (irq_take),
        .entry_o      (entry),
        .bad_o        (bad_trap),
        .code_o       (entry_code)
    );

    trap_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .step_i       (step_i),
        .count_i      (s_q.count),
        .compare_i    (s_q.compare),
        .count_next_o (count_next),
        .hit_o        (tmr_hit)
    );

    always_comb begin
        sel = ctl_sel_e'(wr_sel_i);
        s_d = s_q;
        s_d.count = count_next;

        // software writes lose against a trap entry in the same cycle
        if (wr_en_i && !entry) begin
            case (sel)
                SEL_STATUS:  s_d.status  = filter_status(wr_data_i[ST_W-1:0],
                                                         HAS_RV64, HAS_FPU, HAS_COMPACT);
                SEL_CAUSE:   s_d.cause   = wr_data_i[CA_W-1:0] & ~CA_RSV_MASK;
                SEL_EVEC:    s_d.evec    = wr_data_i;
                SEL_COMPARE: s_d.compare = CNT_W'(wr_data_i);
                SEL_EPC:     s_d.epc     = wr_data_i;
                default: ;
            endcase
        end

        if (entry) begin
            s_d.status[ST_TE]   = 1'b0;
            s_d.status[ST_SUP]  = 1'b1;
            s_d.status[ST_PSUP] = s_q.status[ST_SUP];
            s_d.cause[CODE_W-1:0] = entry_code;
            s_d.epc     = pc_i;
            s_d.badaddr = bad_addr_i;
            s_d.rpc     = s_q.evec;
        end

        s_d.cause[CA_PEND +: NIRQ] = s_d.cause[CA_PEND +: NIRQ] | irq_set_i;
        if (tmr_hit) s_d.cause[TMR_BIT] = 1'b1;

        s_d.redirect = entry;
        s_d.err      = s_q.err | bad_trap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{status: ST_RST, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status_o      = s_q.status;
        cause_o       = s_q.cause;
        epc_o         = s_q.epc;
        evec_o        = s_q.evec;
        badaddr_o     = s_q.badaddr;
        count_o       = s_q.count;
        compare_o     = s_q.compare;
        redirect_o    = s_q.redirect;
        redirect_pc_o = s_q.rpc;
        err_o         = s_q.err;
        xlen_o = (s_q.status[ST_SUP] ? s_q.status[ST_S64] : s_q.status[ST_U64]) ? 7'd64 : 7'd32;
    end

    // R2: reserved status bit never reads as one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.status[ST_RSV] == 1'b0);

    // R4: interrupts only with traps enabled and at a boundary
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (s_q.status[ST_TE] && step_i));

    // R5: entry leaves traps disabled in supervisor mode with a redirect
    a_r5_entry_state: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (!s_q.status[ST_TE] && s_q.status[ST_SUP] && s_q.redirect));

    // R5: previous supervisor bit captures the old mode
    a_r5_prev_sup: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (s_q.status[ST_PSUP] == $past(s_q.status[ST_SUP])));

    // R6: saved PC and handler target
    a_r6_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (s_q.epc == $past(pc_i) && s_q.rpc == $past(s_q.evec)));

    // R7: one increment per retired instruction
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (s_q.count == $past(s_q.count) + CNT_W'(1)));

    // R8: trap with traps disabled flags an error and does not enter
    a_r8_disabled_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid_i && !s_q.status[ST_TE]) |=> (s_q.err && !s_q.redirect));
endmodule

// File: tb/tb_trap_ctrl.sv
`timescale 1ns/1ps
module tb_trap_ctrl;
    localparam int AW = 32;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          step_i, trap_valid_i, wr_en_i;
    logic [AW-1:0] pc_i, bad_addr_i, wr_data_i;
    logic [4:0]    trap_code_i;
    logic [7:0]    irq_set_i;
    logic [2:0]    wr_sel_i;
    logic [15:0]   status_o, cause_o;
    logic [AW-1:0] epc_o, evec_o, badaddr_o, redirect_pc_o;
    logic [CW-1:0] count_o, compare_o;
    logic          redirect_o, err_o;
    logic [6:0]    xlen_o;

    int n_checks = 0;
    int n_errors = 0;

    // model state
    logic [15:0]   m_st, m_ca;
    logic [AW-1:0] m_epc, m_evec, m_bad, m_rpc;
    logic [CW-1:0] m_cnt, m_cmp;
    logic          m_red, m_err;

    trap_ctrl dut (
        .clk, .rst_n, .step_i, .pc_i, .trap_valid_i, .trap_code_i, .bad_addr_i,
        .irq_set_i, .wr_en_i, .wr_sel_i, .wr_data_i, .status_o, .cause_o,
        .epc_o, .evec_o, .badaddr_o, .count_o, .compare_o, .redirect_o,
        .redirect_pc_o, .xlen_o, .err_o
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // default build: 64-bit on, FPU off, compressed off
    function automatic logic [15:0] exp_filter(input logic [15:0] v);
        return v & 16'hFFF1;
    endfunction

    function automatic logic [6:0] exp_xlen(input logic [15:0] s);
        logic w;
        w = s[6] ? s[5] : s[4];
        return w ? 7'd64 : 7'd32;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        step_i = 0; trap_valid_i = 0; wr_en_i = 0; irq_set_i = '0;
        trap_code_i = '0; wr_sel_i = '0; wr_data_i = '0;
    endtask

    task automatic compare_all();
        chk("R5 status",      32'(status_o), 32'(m_st));
        chk("R6 cause",       32'(cause_o),  32'(m_ca));
        chk("R6 epc",         epc_o,         m_epc);
        chk("R11 evec",       evec_o,        m_evec);
        chk("R6 badaddr",     badaddr_o,     m_bad);
        chk("R7 count",       count_o,       m_cnt);
        chk("R11 compare",    compare_o,     m_cmp);
        chk("R4 redirect",    32'(redirect_o), 32'(m_red));
        chk("R6 redirect_pc", redirect_pc_o, m_rpc);
        chk("R3 xlen",        32'(xlen_o),   32'(exp_xlen(m_st)));
        chk("R8 err",         32'(err_o),    32'(m_err));
    endtask

    // called after inputs are driven (just after a falling edge)
    task automatic tick();
        logic te, irq, ok, entry, hit;
        logic [15:0] n_st, n_ca;
        logic [AW-1:0] n_epc, n_evec, n_bad, n_rpc;
        logic [CW-1:0] n_cnt, n_cmp;
        te    = m_st[0];
        irq   = step_i && te && ((m_ca[15:8] & m_st[15:8]) != 0);
        ok    = trap_valid_i && !irq && te && (trap_code_i < 5'd16);
        entry = irq || ok;
        hit   = step_i && (m_cnt == m_cmp);
        n_st = m_st; n_ca = m_ca; n_epc = m_epc; n_evec = m_evec;
        n_bad = m_bad; n_rpc = m_rpc; n_cmp = m_cmp;
        n_cnt = step_i ? m_cnt + 1 : m_cnt;
        if (wr_en_i && !entry) begin
            case (wr_sel_i)
                3'd0: n_st   = exp_filter(wr_data_i[15:0]);
                3'd1: n_ca   = wr_data_i[15:0] & 16'hFF1F;
                3'd2: n_evec = wr_data_i;
                3'd3: n_cmp  = wr_data_i;
                3'd4: n_epc  = wr_data_i;
                default: ;
            endcase
        end
        if (entry) begin
            n_st[0] = 1'b0; n_st[6] = 1'b1; n_st[7] = m_st[6];
            n_ca[4:0] = irq ? 5'd31 : trap_code_i;
            n_epc = pc_i; n_bad = bad_addr_i; n_rpc = m_evec;
        end
        n_ca[15:8] = n_ca[15:8] | irq_set_i;
        if (hit) n_ca[15] = 1'b1;
        m_err = m_err | (trap_valid_i && !irq && !ok);
        m_red = entry;
        m_st = n_st; m_ca = n_ca; m_epc = n_epc; m_evec = n_evec;
        m_bad = n_bad; m_rpc = n_rpc; m_cnt = n_cnt; m_cmp = n_cmp;
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle();
    endtask

    task automatic do_reset();
        idle();
        pc_i = '0; bad_addr_i = '0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_st = 16'h0060; m_ca = '0; m_epc = '0; m_evec = '0; m_bad = '0;
        m_rpc = '0; m_cnt = '0; m_cmp = '0; m_red = 0; m_err = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
        tick();
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset state
        chk("R1 status", 32'(status_o), 32'h0060);
        chk("R1 cause", 32'(cause_o), 32'h0);
        chk("R1 count", count_o, 32'h0);
        chk("R1 redirect/err", 32'({redirect_o, err_o}), 32'h0);
        chk("R1 xlen", 32'(xlen_o), 32'd64);

        // R2 filtering
        wr(3'd0, 32'h0000FFFF);
        chk("R2 filtered status", 32'(status_o), 32'hFFF1);

        // R3 width selection in user mode
        wr(3'd0, 32'h00000010);
        chk("R3 user64", 32'(xlen_o), 32'd64);
        wr(3'd0, 32'h00000020);
        chk("R3 user32", 32'(xlen_o), 32'd32);

        // R10 interrupt beats a simultaneous synchronous trap
        wr(3'd2, 32'h00000100);
        wr(3'd0, 32'h00000401);
        irq_set_i = 8'h04; tick();
        step_i = 1; pc_i = 32'h40; trap_valid_i = 1; trap_code_i = 5'd3;
        bad_addr_i = 32'hBAD0; tick();
        chk("R10 code", 32'(cause_o[4:0]), 32'd31);
        chk("R10 redirect", 32'(redirect_o), 32'd1);
        chk("R10 no err", 32'(err_o), 32'd0);
        chk("R6 target", redirect_pc_o, 32'h100);
        chk("R5 psup", 32'(status_o[7:6]), 32'b01);

        // R8 trap with traps disabled
        trap_valid_i = 1; trap_code_i = 5'd2; pc_i = 32'h80; tick();
        chk("R8 err", 32'(err_o), 32'd1);
        chk("R8 epc kept", epc_o, 32'h40);

        // R9 undefined trap number
        do_reset();
        wr(3'd0, 32'h00000001);
        trap_valid_i = 1; trap_code_i = 5'd20; tick();
        chk("R9 err", 32'(err_o), 32'd1);
        chk("R9 no redirect", 32'(redirect_o), 32'd0);

        // R7 timer hit
        do_reset();
        wr(3'd3, 32'd2);
        repeat (4) begin step_i = 1; tick(); end
        chk("R7 timer pending", 32'(cause_o[15]), 32'd1);
        chk("R7 count", count_o, 32'd4);

        // R11 write during trap entry discarded, unknown selector ignored
        do_reset();
        wr(3'd0, 32'h00000001);
        wr(3'd7, 32'hFFFFFFFF);
        chk("R11 unknown sel", 32'(status_o), 32'h0001);
        trap_valid_i = 1; trap_code_i = 5'd5; wr_en_i = 1; wr_sel_i = 3'd2;
        wr_data_i = 32'h200; tick();
        chk("R11 evec kept", evec_o, 32'h0);
        chk("R6 code", 32'(cause_o[4:0]), 32'd5);

        // random phase
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step_i       = ($urandom % 2) == 0;
            pc_i         = $urandom & 32'hFFFF_FFFC;
            bad_addr_i   = $urandom;
            trap_valid_i = ($urandom % 5) == 0;
            trap_code_i  = 5'($urandom);
            irq_set_i    = (($urandom % 16) == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
            wr_en_i      = ($urandom % 4) == 0;
            wr_sel_i     = 3'($urandom % 6);
            wr_data_i    = $urandom;
            if (wr_en_i && wr_sel_i == 3'd0 && ($urandom % 2) == 0) wr_data_i[0] = 1'b1;
            if (wr_en_i && wr_sel_i == 3'd3) wr_data_i = m_cnt + ($urandom % 8);
            tick();
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule